// File: doc/BRIEF.md
# Quarter-Rate IF Down-Converter

This block turns a stream of signed 14-bit samples of a 60 MHz intermediate frequency, taken at 80 MSPS, into complex baseband. Sampled at that rate, the IF folds onto one quarter of the sample clock. Because of this, the local oscillator only ever takes the values 1, 0 and -1. The mixer then reduces to passing, negating or zeroing each sample, and no multiplier is needed. The in-phase and quadrature products each pass through a four-sample moving sum. This sum removes the image at twice the IF, inside a signal bandwidth of roughly 10 MHz. A magnitude estimate follows, which a downstream pulse detector can threshold.

Samples enter with a qualifying valid bit. Each accepted sample produces exactly one output beat, a fixed number of cycles later. The beat carries the filtered I, the filtered Q and the amplitude estimate. Idle cycles between samples freeze the whole pipeline, so gaps in the input change neither the oscillator phase nor the filter contents.

Top module: `ddc_top`

## Requirements
- R1: After reset, outValid is 0 and outI, outQ and outMag are 0. The filter history is cleared and the oscillator phase returns to 0, so the first sample accepted after reset is handled as sample index 0.
- R2: Each cycle with inValid high accepts one sample. outValid is high exactly three clock edges after the accepting edge, once per accepted sample, and at no other time.
- R3: For the sample with index k (counted from 0 after reset), the mixed in-phase value is x times c and the mixed quadrature value is x times s. Here (c, s) is (1,0), (0,-1), (-1,0) or (0,1) for k mod 4 equal to 0, 1, 2 or 3.
- R4: Cycles with inValid low advance neither the phase index nor the filter history.
- R5: outI is the signed sum of the mixed in-phase values of the current sample and the three samples before it. Samples missing since reset count as 0.
- R6: outQ is the same four-sample signed sum of the mixed quadrature values.
- R7: outMag equals max(|outI|,|outQ|) + floor(min(|outI|,|outQ|)/2).
- R8: Full-scale inputs (-8192 and 8191) give exact results without wrap-around. outI and outQ are 17-bit signed and outMag is 18-bit unsigned.
- R9: While outValid is low, outI, outQ and outMag hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies inSample in this cycle |
| inSample | input | 14 | Signed IF sample |
| outValid | output | 1 | Output beat present |
| outI | output | 17 | Filtered in-phase value, signed |
| outQ | output | 17 | Filtered quadrature value, signed |
| outMag | output | 18 | Amplitude estimate, unsigned |

## Verification
A phase index that slips by even one step moves energy between outI and outQ. It also flips signs, and the first beat after the slip shows this. The bench compares every beat of a hand-worked sequence with irregular gaps, so a phase or history error shows three cycles after the faulty sample. A stale filter history stays visible for up to four beats. A valid pipeline that is too long or too short is caught on the first sample, both by the cycle count and by the isolated-pulse test.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  // Quarter-rate oscillator: four phases per IF cycle.
  localparam int PHASE_W = 2;

  // Strobes from the sequencer into the arithmetic path.
  typedef struct packed {
    logic               mixEn;  // capture mixer products
    logic               sumEn;  // shift filter history, register sums
    logic               magEn;  // register outputs and magnitude
    logic [PHASE_W-1:0] phase;  // oscillator phase of the incoming sample
  } ddc_strobe_t;

endpackage

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ddc_strobe_t strobe,
  output logic        outValid
);

  logic [PHASE_W-1:0] phaseQ;
  logic               stage1Vld;
  logic               stage2Vld;
  logic               stage3Vld;

  // Phase steps only on accepted samples.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (inValid) begin
      phaseQ <= phaseQ + PHASE_W'(1);
    end
  end

  // Valid travels beside the three datapath register stages.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Vld <= 1'b0;
      stage2Vld <= 1'b0;
      stage3Vld <= 1'b0;
    end else begin
      stage1Vld <= inValid;
      stage2Vld <= stage1Vld;
      stage3Vld <= stage2Vld;
    end
  end

  always_comb begin
    strobe.mixEn = inValid;
    strobe.phase = phaseQ;
    strobe.sumEn = stage1Vld;
    strobe.magEn = stage2Vld;
  end

  assign outValid = stage3Vld;

endmodule

// File: rtl/ddc_movsum.sv
module ddc_movsum #(
  parameter  int IN_W      = 15,
  parameter  int TAPS_LOG2 = 2,
  localparam int TAPS      = 1 << TAPS_LOG2,
  localparam int OUT_W     = IN_W + TAPS_LOG2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);

  // Older samples; the newest one is din itself.
  logic signed [IN_W-1:0]  hist [TAPS-1];
  logic signed [OUT_W-1:0] acc;

  always_comb begin
    acc = OUT_W'(din);
    for (int i = 0; i < TAPS - 1; i++) begin
      acc = acc + OUT_W'(hist[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist[0] <= '0;
    end else if (en) begin
      hist[0] <= din;
    end
  end

  for (genvar g = 1; g < TAPS - 1; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hist[g] <= '0;
      end else if (en) begin
        hist[g] <= hist[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dout <= '0;
    end else if (en) begin
      dout <= acc;
    end
  end

endmodule

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
#(
  parameter  int DATA_W    = 14,
  parameter  int TAPS_LOG2 = 2,
  localparam int MIX_W     = DATA_W + 1,
  localparam int SUM_W     = MIX_W + TAPS_LOG2,
  localparam int MAG_W     = SUM_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ddc_strobe_t             strobe,
  input  logic signed [DATA_W-1:0] inSample,
  output logic signed [SUM_W-1:0] outI,
  output logic signed [SUM_W-1:0] outQ,
  output logic        [MAG_W-1:0] outMag
);

  logic signed [MIX_W-1:0] sampleWide;
  logic signed [MIX_W-1:0] sampleNeg;
  logic signed [MIX_W-1:0] mixI;
  logic signed [MIX_W-1:0] mixQ;
  logic signed [MIX_W-1:0] mixIReg;
  logic signed [MIX_W-1:0] mixQReg;
  logic signed [SUM_W-1:0] sumI;
  logic signed [SUM_W-1:0] sumQ;
  logic        [SUM_W-1:0] absI;
  logic        [SUM_W-1:0] absQ;
  logic        [SUM_W-1:0] bigPart;
  logic        [SUM_W-1:0] smallPart;
  logic        [MAG_W-1:0] magNext;

  // One extra bit so that negating the most negative sample is exact.
  assign sampleWide = MIX_W'(inSample);
  assign sampleNeg  = -sampleWide;

  // Oscillator values are 1, 0 or -1: select, negate or zero.
  always_comb begin
    unique case (strobe.phase)
      2'd0:    begin mixI = sampleWide; mixQ = '0;         end
      2'd1:    begin mixI = '0;         mixQ = sampleNeg;  end
      2'd2:    begin mixI = sampleNeg;  mixQ = '0;         end
      default: begin mixI = '0;         mixQ = sampleWide; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mixIReg <= '0;
      mixQReg <= '0;
    end else if (strobe.mixEn) begin
      mixIReg <= mixI;
      mixQReg <= mixQ;
    end
  end

  // Same filter on both rails.
  for (genvar ch = 0; ch < 2; ch++) begin : g_rail
    if (ch == 0) begin : g_i
      ddc_movsum #(.IN_W(MIX_W), .TAPS_LOG2(TAPS_LOG2)) u_sum (
        .clk (clk),
        .rstN(rstN),
        .en  (strobe.sumEn),
        .din (mixIReg),
        .dout(sumI)
      );
    end else begin : g_q
      ddc_movsum #(.IN_W(MIX_W), .TAPS_LOG2(TAPS_LOG2)) u_sum (
        .clk (clk),
        .rstN(rstN),
        .en  (strobe.sumEn),
        .din (mixQReg),
        .dout(sumQ)
      );
    end
  end

  // Alpha-max plus half beta-min estimate.
  always_comb begin
    absI = sumI[SUM_W-1] ? SUM_W'(-sumI) : SUM_W'(sumI);
    absQ = sumQ[SUM_W-1] ? SUM_W'(-sumQ) : SUM_W'(sumQ);
    if (absI >= absQ) begin
      bigPart   = absI;
      smallPart = absQ;
    end else begin
      bigPart   = absQ;
      smallPart = absI;
    end
    magNext = MAG_W'(bigPart) + MAG_W'(smallPart >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outI   <= '0;
      outQ   <= '0;
      outMag <= '0;
    end else if (strobe.magEn) begin
      outI   <= sumI;
      outQ   <= sumQ;
      outMag <= magNext;
    end
  end

endmodule

// File: rtl/ddc_top.sv
module ddc_top
  import ddc_pkg::*;
#(
  parameter  int DATA_W    = 14,
  parameter  int TAPS_LOG2 = 2,
  localparam int SUM_W     = DATA_W + 1 + TAPS_LOG2,
  localparam int MAG_W     = SUM_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [SUM_W-1:0]  outI,
  output logic signed [SUM_W-1:0]  outQ,
  output logic        [MAG_W-1:0]  outMag
);

  ddc_strobe_t strobe;

  ddc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  ddc_datapath #(.DATA_W(DATA_W), .TAPS_LOG2(TAPS_LOG2)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inSample(inSample),
    .outI    (outI),
    .outQ    (outQ),
    .outMag  (outMag)
  );

endmodule

// File: rtl/ddc_checker.sv
module ddc_checker #(
  parameter  int DATA_W    = 14,
  parameter  int TAPS_LOG2 = 2,
  localparam int SUM_W     = DATA_W + 1 + TAPS_LOG2,
  localparam int MAG_W     = SUM_W + 1,
  localparam int LIMIT     = ((1 << TAPS_LOG2) / 2) * (1 << (DATA_W - 1))
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    outValid,
  input logic signed [SUM_W-1:0] outI,
  input logic signed [SUM_W-1:0] outQ,
  input logic        [MAG_W-1:0] outMag
);

  int valI;
  int valQ;
  int magAbsI;
  int magAbsQ;
  int magVal;
  int bigAbs;

  always_comb begin
    valI    = int'(outI);
    valQ    = int'(outQ);
    magAbsI = (valI < 0) ? -valI : valI;
    magAbsQ = (valQ < 0) ? -valQ : valQ;
    bigAbs  = (magAbsI > magAbsQ) ? magAbsI : magAbsQ;
    magVal  = int'(outMag);
  end

  // R2: an accepted sample always yields a beat three edges later
  p_beat_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid, 3) |-> outValid);

  // R2: no beat without a sample three edges earlier
  p_beat_has_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3));

  // R7: estimate lies between the larger rail and the sum of both rails
  p_mag_bounds_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (magVal >= bigAbs) && (magVal <= magAbsI + magAbsQ));

  // R8: filtered rails stay within the reachable range
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (magAbsI <= LIMIT) && (magAbsQ <= LIMIT));

  // R9: outputs frozen between beats
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outI) && $stable(outQ) && $stable(outMag)));

endmodule

bind ddc_top ddc_checker #(.DATA_W(DATA_W), .TAPS_LOG2(TAPS_LOG2)) u_ddcChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outI    (outI),
  .outQ    (outQ),
  .outMag  (outMag)
);

// File: tb/tb_ddc_top.sv
module tb_ddc_top;

  localparam int DATA_W = 14;
  localparam int SUM_W  = 17;
  localparam int MAG_W  = 18;
  localparam int NVEC   = 8;
  localparam int CAPN   = 64;

  // Hand-worked sequence from reset: sample, idle cycles before it,
  // expected filtered I, Q and magnitude.
  localparam int vecX   [NVEC] = '{100, 50, -30, 20, 10, -40, 60, 5};
  localparam int vecGap [NVEC] = '{0, 0, 2, 0, 1, 0, 3, 0};
  localparam int vecI   [NVEC] = '{100, 100, 130, 130, 40, 40, -50, -50};
  localparam int vecQ   [NVEC] = '{0, -50, -50, -30, -30, 60, 60, 45};
  localparam int vecM   [NVEC] = '{100, 125, 155, 145, 55, 80, 85, 72};

  logic                     clk = 1'b0;
  logic                     rstN;
  logic                     inValid;
  logic signed [DATA_W-1:0] inSample;
  logic                     outValid;
  logic signed [SUM_W-1:0]  outI;
  logic signed [SUM_W-1:0]  outQ;
  logic        [MAG_W-1:0]  outMag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int capCount = 0;
  int capI   [CAPN];
  int capQ   [CAPN];
  int capM   [CAPN];
  int capCyc [CAPN];
  int drvCyc [NVEC];
  bit timedOut = 1'b0;

  always #2 clk = ~clk;

  ddc_top dut (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSample(inSample),
    .outValid(outValid),
    .outI    (outI),
    .outQ    (outQ),
    .outMag  (outMag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Records every output beat, sampled away from the clock edge.
  always @(negedge clk) begin
    if (outValid && capCount < CAPN) begin
      capI[capCount]   = int'(outI);
      capQ[capCount]   = int'(outQ);
      capM[capCount]   = int'(outMag);
      capCyc[capCount] = cyc;
      capCount         = capCount + 1;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic runTests();
    int base;
    int lastI;
    int lastQ;
    int lastM;

    rstN = 1'b0; inValid = 1'b0; inSample = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 outI", int'(outI), 0);
    chk("R1 outQ", int'(outQ), 0);
    chk("R1 outMag", int'(outMag), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R3 R4 R5 R6 R7, with gaps for R4
    base = capCount;
    for (int k = 0; k < NVEC; k++) begin
      for (int g = 0; g < vecGap[k]; g++) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid  = 1'b1;
      inSample = DATA_W'(vecX[k]);
      drvCyc[k] = cyc;
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 beat count", capCount - base, NVEC);
    for (int k = 0; k < NVEC; k++) begin
      chk("R2 latency", capCyc[base+k] - drvCyc[k], 3);
      chk("R5 R3 R4 outI", capI[base+k], vecI[k]);
      chk("R6 R3 R4 outQ", capQ[base+k], vecQ[k]);
      chk("R7 outMag", capM[base+k], vecM[k]);
    end

    // Isolated sample, R2 cycle by cycle; index 8, phase 0
    inValid = 1'b1; inSample = DATA_W'(7);
    @(negedge clk);
    inValid = 1'b0;
    chk("R2 edge1", int'(outValid), 0);
    @(negedge clk);
    chk("R2 edge2", int'(outValid), 0);
    @(negedge clk);
    chk("R2 edge3", int'(outValid), 1);
    chk("R5 outI", int'(outI), -53);
    chk("R6 outQ", int'(outQ), 45);
    chk("R7 outMag", int'(outMag), 75);
    lastI = int'(outI); lastQ = int'(outQ); lastM = int'(outMag);
    @(negedge clk);
    chk("R2 edge4", int'(outValid), 0);

    // R9: outputs held across idle cycles
    repeat (5) @(negedge clk);
    chk("R9 outValid", int'(outValid), 0);
    chk("R9 outI", int'(outI), lastI);
    chk("R9 outQ", int'(outQ), lastQ);
    chk("R9 outMag", int'(outMag), lastM);

    // R1 mid-run reset, then R8 full-scale burst back to back
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outI after reset", int'(outI), 0);
    chk("R1 outMag after reset", int'(outMag), 0);
    rstN = 1'b1;
    @(negedge clk);
    base = capCount;
    inValid = 1'b1;
    inSample = DATA_W'(-8192); @(negedge clk);
    inSample = DATA_W'(-8192); @(negedge clk);
    inSample = DATA_W'(8191);  @(negedge clk);
    inSample = DATA_W'(8191);  @(negedge clk);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 beat count", capCount - base, 4);
    chk("R1 R3 phase restart I", capI[base], -8192);
    chk("R1 R3 phase restart Q", capQ[base], 0);
    chk("R8 outMag k0", capM[base], 8192);
    chk("R8 outI k1", capI[base+1], -8192);
    chk("R8 outQ k1", capQ[base+1], 8192);
    chk("R8 outMag k1", capM[base+1], 12288);
    chk("R8 outI k3", capI[base+3], -16383);
    chk("R8 outQ k3", capQ[base+3], 16383);
    chk("R8 outMag k3", capM[base+3], 24574);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule